// File: doc/BRIEF.md
# Per-Probe Trigger Unit

This block watches a set of equal-width probe signals and raises a single trigger pulse toward a capture controller when any probe meets its own condition. Every probe owns two host-visible registers: an operation selector and a comparison argument. On every clock the block tests each probe against its selected operation and ORs the per-probe results. The OR is registered, so the trigger appears one clock after the sample that caused it.

The supported operations are equality with the argument, inequality with the argument, and change since the previous sample. Any other code disables the probe. Each probe keeps its previous value in a register that is updated on every clock, so change detection always compares two consecutive samples. The host reaches the registers through a simple write strobe and address, and reads them back through a combinational read port.

Top module: `trig_unit`

## Requirements
- R1: After reset, `trig_o` is 0 and every operation and argument register reads 0.
- R2: Probe k's operation register is at address 2k and its argument register at 2k+1. The operation register stores the low 4 bits of `wdata_i` and reads them back unchanged, zero-extended. The argument register stores all `PROBE_W` bits.
- R3: Operation code 8 makes probe k fire when its value equals its argument.
- R4: Operation code 3 makes probe k fire when its value differs from its value on the previous clock. Before the first post-reset sample, the previous value is 0.
- R5: Operation code 0 disables the probe, so it never contributes to the trigger.
- R6: Operation code 9 fires when the probe differs from its argument. Every code other than 3, 8 and 9 behaves like code 0.
- R7: `trig_o` is the OR of all per-probe results. A single firing probe is enough.
- R8: `trig_o` reflects the probe values present at the previous rising clock edge, which is exactly one cycle of latency.
- R9: Writes to addresses at or above 2*N_PROBES change no register, and reads there return 0.
- R10: A register write takes effect for the comparison made at the next clock edge. The sample taken at the write edge is judged with the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for write and read |
| wdata_i | input | PROBE_W | Write data |
| rdata_o | output | PROBE_W | Read data for `addr_i` (combinational) |
| probe_i | input | N_PROBES*PROBE_W | Probe values, probe k at bits [k*PROBE_W +: PROBE_W] |
| trig_o | output | 1 | Registered trigger |

## Verification
A host write to an operation or argument register can land on the same clock edge at which the probes are sampled. That edge must still be judged with the old setting. The bench provokes this case in two ways: it rewrites a probe's operation while that probe already equals its argument, and it rewrites an argument to match a probe that holds steady. A behavioural reference model applies the write only after evaluating the sample at that edge, and the bench compares `trig_o` against the model on every clock. Change detection on the write edge is exercised too, so any reordering of register update against previous-value update shows up as a one-cycle mismatch.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_OFF = 4'd0,
    OP_CHG = 4'd3,
    OP_EQ  = 4'd8,
    OP_NEQ = 4'd9
  } trig_op_e;
endpackage

// File: rtl/trig_regs.sv
module trig_regs
  import trig_pkg::*;
#(
  parameter int N_PROBES = 4,
  parameter int PROBE_W  = 8,
  parameter int ADDR_W   = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  wr_en_i,
  input  logic [ADDR_W-1:0]                     addr_i,
  input  logic [PROBE_W-1:0]                    wdata_i,
  output logic [PROBE_W-1:0]                    rdata_o,
  output logic [N_PROBES-1:0][OP_W-1:0]         op_o,
  output logic [N_PROBES-1:0][PROBE_W-1:0]      arg_o
);
  localparam int N_SLOTS = 2 * N_PROBES;

  logic [N_PROBES-1:0][OP_W-1:0]    op_q;
  logic [N_PROBES-1:0][PROBE_W-1:0] arg_q;

  for (genvar k = 0; k < N_PROBES; k++) begin : g_reg
    localparam logic [ADDR_W-1:0] OP_ADDR  = ADDR_W'(2 * k);
    localparam logic [ADDR_W-1:0] ARG_ADDR = ADDR_W'(2 * k + 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        op_q[k]  <= '0;
        arg_q[k] <= '0;
      end else if (wr_en_i) begin
        if (addr_i == OP_ADDR)  op_q[k]  <= wdata_i[OP_W-1:0];
        if (addr_i == ARG_ADDR) arg_q[k] <= wdata_i;
      end
    end

    // R2
    op_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == OP_ADDR) |=> op_q[k] == $past(wdata_i[OP_W-1:0]));
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_PROBES; k++) begin
      if (addr_i == ADDR_W'(2 * k))     rdata_o = PROBE_W'(op_q[k]);
      if (addr_i == ADDR_W'(2 * k + 1)) rdata_o = arg_q[k];
    end
  end

  assign op_o  = op_q;
  assign arg_o = arg_q;

  // R9
  no_stray_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && 32'(addr_i) >= N_SLOTS) |=> ($stable(op_q) && $stable(arg_q)));
endmodule

// File: rtl/trig_cmp.sv
module trig_cmp
  import trig_pkg::*;
#(
  parameter int PROBE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic [OP_W-1:0]    op_i,
  input  logic [PROBE_W-1:0] arg_i,
  output logic               hit_o
);
  logic [PROBE_W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= probe_i;
  end

  always_comb begin
    unique case (op_i)
      OP_EQ:   hit_o = (probe_i == arg_i);
      OP_NEQ:  hit_o = (probe_i != arg_i);
      OP_CHG:  hit_o = (probe_i != prev_q);
      default: hit_o = 1'b0;
    endcase
  end

  // R5
  off_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_OFF) |-> !hit_o);

  // R3
  eq_fires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_EQ && probe_i == arg_i) |-> hit_o);
endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_pkg::*;
#(
  parameter int N_PROBES = 4,
  parameter int PROBE_W  = 8,
  parameter int ADDR_W   = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [PROBE_W-1:0]            wdata_i,
  output logic [PROBE_W-1:0]            rdata_o,
  input  logic [N_PROBES*PROBE_W-1:0]   probe_i,
  output logic                          trig_o
);
  logic [N_PROBES-1:0][OP_W-1:0]    op;
  logic [N_PROBES-1:0][PROBE_W-1:0] arg;
  logic [N_PROBES-1:0]              hit;
  logic                             trig_q;

  trig_regs #(
    .N_PROBES(N_PROBES), .PROBE_W(PROBE_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .op_o    (op),
    .arg_o   (arg)
  );

  for (genvar k = 0; k < N_PROBES; k++) begin : g_cmp
    trig_cmp #(.PROBE_W(PROBE_W)) u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .probe_i (probe_i[k*PROBE_W +: PROBE_W]),
      .op_i    (op[k]),
      .arg_i   (arg[k]),
      .hit_o   (hit[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= |hit;
  end

  assign trig_o = trig_q;

  // R8
  trig_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> trig_o == $past(|hit));

  // R7
  any_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> trig_o);
endmodule

// File: tb/trig_unit_tb.sv
`timescale 1ns/1ps
module trig_unit_tb_top;
  localparam int N = 4;
  localparam int W = 8;
  localparam int A = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [A-1:0]   addr = '0;
  logic [W-1:0]   wdata = '0;
  logic [W-1:0]   rdata;
  logic [N*W-1:0] probe = '0;
  logic           trig;

  int total = 0;
  int bad = 0;

  int mop [N];
  int marg[N];
  int mprev[N];
  bit exp_trig;

  always #5 clk = ~clk;

  trig_unit #(.N_PROBES(N), .PROBE_W(W), .ADDR_W(A)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .probe_i(probe), .trig_o(trig)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit mhit(int k, logic [N*W-1:0] pv);
    int v = int'(pv[k*W +: W]);
    case (mop[k])
      8: return v == marg[k];
      9: return v != marg[k];
      3: return v != mprev[k];
      default: return 1'b0;
    endcase
  endfunction

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit we, int a, int d, logic [N*W-1:0] pv, string tag);
    bit h = 1'b0;
    wr_en = we; addr = A'(a); wdata = W'(d); probe = pv;
    @(posedge clk);
    for (int k = 0; k < N; k++) h |= mhit(k, pv);
    exp_trig = h;
    for (int k = 0; k < N; k++) mprev[k] = int'(pv[k*W +: W]);
    if (we && a < 2*N) begin
      if (a % 2 == 0) mop[a/2] = d & 15;
      else            marg[a/2] = d & 255;
    end
    @(negedge clk);
    chk(trig == exp_trig, tag, int'(trig), int'(exp_trig));
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, string tag);
    int e = 0;
    if (a < 2*N) e = (a % 2 == 0) ? mop[a/2] : marg[a/2];
    addr = A'(a);
    #1;
    chk(int'(rdata) == e, tag, int'(rdata), e);
  endtask

  function automatic logic [N*W-1:0] pk(int p0, int p1, int p2, int p3);
    return {W'(p3), W'(p2), W'(p1), W'(p0)};
  endfunction

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin mop[k] = 0; marg[k] = 0; mprev[k] = 0; end
    #23;
    // R1 reset state
    chk(trig == 1'b0, "R1 trig", int'(trig), 0);
    for (int a = 0; a < 2*N; a++) rd(a, "R1 regs");
    @(negedge clk); rst_n = 1'b1;

    // R5 all off, probes moving
    for (int i = 0; i < 6; i++) step(0, 0, 0, pk(i, 3*i, 255-i, i*7), "R5 off");

    // R2 map and readback
    step(1, 0, 8'hF8, pk(0,0,0,0), "R2 wr");
    step(1, 1, 8'h5A, pk(0,0,0,0), "R2 wr");
    step(1, 2, 8'hF3, pk(0,0,0,0), "R2 wr");
    step(1, 3, 8'hC1, pk(0,0,0,0), "R2 wr");
    for (int a = 0; a < 2*N; a++) rd(a, "R2 readback");

    // R3 equality on probe0, R10 same-edge cases
    step(0, 0, 0, pk(8'h5A,0,0,0), "R3 eq");
    step(0, 0, 0, pk(8'h5A,0,0,0), "R3 eq hold");
    step(0, 0, 0, pk(8'h5B,0,0,0), "R3 eq miss");
    step(1, 1, 8'h5B, pk(8'h5B,0,0,0), "R10 arg write edge");
    step(0, 0, 0, pk(8'h5B,0,0,0), "R10 arg after");
    step(1, 0, 0, pk(8'h5B,0,0,0), "R10 op off edge");
    step(0, 0, 0, pk(8'h5B,0,0,0), "R10 op off after");

    // R4 change on probe1 (op=3 from 0xF3)
    step(0, 0, 0, pk(0,4,0,0), "R4 change");
    step(0, 0, 0, pk(0,4,0,0), "R4 steady");
    step(0, 0, 0, pk(0,5,0,0), "R4 change");
    step(1, 2, 3, pk(0,6,0,0), "R4 change on write edge");

    // R6 code 9 and unused codes on probe2
    step(1, 2, 0, pk(0,6,0,0), "R6 setup");
    step(1, 5, 8'h10, pk(0,6,8'h10,0), "R6 setup");
    step(1, 4, 9, pk(0,6,8'h10,0), "R6 setup");
    step(0, 0, 0, pk(0,6,8'h10,0), "R6 neq match");
    step(0, 0, 0, pk(0,6,8'h11,0), "R6 neq fires");
    for (int c = 1; c < 16; c++) begin
      if (c == 3 || c == 8 || c == 9) continue;
      step(1, 4, c, pk(0,6,8'h10,c), "R6 unused code");
      step(0, 0, 0, pk(0,6,8'h10,255-c), "R6 unused code");
      step(0, 0, 0, pk(0,6,8'h11,c), "R6 unused code");
    end

    // R7 OR of probes: several enabled, one or many firing
    step(1, 4, 9, pk(0,0,8'h10,0), "R7 setup");
    step(1, 6, 8, pk(0,0,8'h10,0), "R7 setup");
    step(1, 7, 8'h77, pk(0,0,8'h10,0), "R7 setup");
    step(1, 0, 8, pk(0,0,8'h10,0), "R7 setup");
    step(0, 0, 0, pk(1,0,8'h10,8'h77), "R7 only p3");
    step(0, 0, 0, pk(8'h5B,0,8'h10,0), "R7 only p0");
    step(0, 0, 0, pk(8'h5B,9,8'h12,8'h77), "R7 all");
    step(0, 0, 0, pk(0,9,8'h10,0), "R7 none");

    // R8 single-cycle pulse alignment
    step(0, 0, 0, pk(0,9,8'h10,8'h77), "R8 pulse");
    step(0, 0, 0, pk(0,9,8'h10,0), "R8 pulse end");

    // R9 out-of-range writes and reads
    for (int a = 2*N; a < (1 << A); a++) begin
      step(1, a, 8'hFF, pk(0,9,8'h10,0), "R9 stray write");
      rd(a, "R9 stray read");
    end
    for (int a = 0; a < 2*N; a++) rd(a, "R9 regs intact");

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule